// File: doc/BRIEF.md
# Shared-Pool Per-Destination Input Queue

This block is one input port of a cell switch that queues at its inputs. Every cell that arrives is held in a single cell memory shared by all destinations. The memory is threaded into one logical queue per output, so a burst of traffic for one output can use the whole pool. Traffic for the other outputs is never stuck behind it, so head-of-line blocking across outputs goes away.

At most one cell arrives per slot. The port takes a free location from a free-location FIFO, writes the cell there, and appends the location to the linked list of the destination's queue. In the next cycle it sends out a routing request that carries the destination and the location.

Output controllers answer with grants that carry a location. The port can serve a grant on every output in the same slot. It delivers each granted cell on the lane of that output and gives the location back to the free FIFO one slot later. When no free location is left, an arriving cell is dropped and counted.

Top module: `shq_input_port`

## Requirements
- R1: After reset, occupancy and drop_cnt read 0, req_valid is low and no out_valid bit is set.
- R2: When a cell is accepted, req_valid is high in the following cycle, with req_dest equal to the cell's destination and req_addr equal to the location it was written to. No request appears in a cycle that follows a cycle without an accepted arrival.
- R3: occupancy counts the locations not in the free FIFO. It rises at the clock edge that accepts a cell. It falls at the second edge after a grant is served, which is one cycle after the cell appears on its output lane.
- R4: A served grant on output o sets out_valid[o] in the next cycle, with lane o of out_data (bits o*DATA_W upward) holding the data written with that cell.
- R5: Each output's queue releases cells in arrival order. A grant whose location is not the head of that output's queue is ignored: no out_valid and no change in occupancy.
- R6: A grant for an output whose queue is empty is ignored.
- R7: Grants on several outputs in the same cycle are all served in that cycle.
- R8: An arrival while occupancy equals DEPTH is dropped. No request is issued, drop_cnt rises by one and occupancy stays unchanged.
- R9: Right after reset, locations are handed out in order 0, 1, 2 and so on. Freed locations are appended to the free FIFO. Those freed in the same slot are appended lowest output index first, and they are handed out again in that order.
- R10: If a queue holds one cell and that cell is served in the same cycle a new cell for that output is accepted, the new cell becomes the head of the queue.

Top module ports use DST_W = clog2(NUM_OUT), AW = clog2(DEPTH) and OCC_W = AW+1. DEPTH is a power of two and at least NUM_OUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A cell arrives this cycle |
| in_dest | input | DST_W | Destination output of the arriving cell |
| in_data | input | DATA_W | Cell payload |
| req_valid | output | 1 | Routing request broadcast |
| req_dest | output | DST_W | Destination carried by the request |
| req_addr | output | AW | Memory location carried by the request |
| grant_valid | input | NUM_OUT | Grant present for each output |
| grant_addr | input | NUM_OUT*AW | Granted location for each output, AW bits per output |
| out_valid | output | NUM_OUT | Cell delivered on each output lane |
| out_data | output | NUM_OUT*DATA_W | Delivered cell data, DATA_W bits per output |
| occupancy | output | OCC_W | Locations currently held |
| drop_cnt | output | CNT_W | Cells lost to a full buffer |

## Verification
The bench fills the pool until it is full, with most cells on one output. This would expose a design that partitions memory per output, because that design would drop cells early. It then checks that freed locations come back in the expected order: a free FIFO that loses or duplicates an entry would hand out the wrong req_addr. Non-head grants and grants to empty queues are sent to catch a design that reads whatever location it is given and corrupts the queue. The bench also serves and appends to a one-cell queue in the same cycle. A design that takes the new head from the stale link would then deliver the wrong data when the next grant for that queue is served.

// File: rtl/shq_input_port.sv
module shq_input_port #(
  parameter int NUM_OUT = 4,
  parameter int DEPTH   = 8,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 16,
  localparam int DST_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  localparam int AW     = $clog2(DEPTH),
  localparam int OCC_W  = AW + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [DST_W-1:0]          in_dest,
  input  logic [DATA_W-1:0]         in_data,
  output logic                      req_valid,
  output logic [DST_W-1:0]          req_dest,
  output logic [AW-1:0]             req_addr,
  input  logic [NUM_OUT-1:0]        grant_valid,
  input  logic [NUM_OUT*AW-1:0]     grant_addr,
  output logic [NUM_OUT-1:0]        out_valid,
  output logic [NUM_OUT*DATA_W-1:0] out_data,
  output logic [OCC_W-1:0]          occupancy,
  output logic [CNT_W-1:0]          drop_cnt
);

  logic [DATA_W-1:0] cell_mem [DEPTH];
  logic [AW-1:0]     link     [DEPTH];
  logic [AW-1:0]     free_q   [DEPTH];
  logic [AW-1:0]     free_rd, free_wr;
  logic [OCC_W-1:0]  free_cnt;

  logic [AW-1:0]     q_head [NUM_OUT];
  logic [AW-1:0]     q_tail [NUM_OUT];
  logic [OCC_W-1:0]  q_len  [NUM_OUT];

  logic [NUM_OUT-1:0] ret_v;
  logic [AW-1:0]      ret_a   [NUM_OUT];
  logic [AW-1:0]      ret_pos [NUM_OUT];
  logic [OCC_W-1:0]   ret_n;

  logic [NUM_OUT-1:0] take;
  logic [NUM_OUT-1:0] push;
  logic               accept;
  logic [AW-1:0]      new_addr;

  assign accept    = in_valid && (free_cnt != '0);
  assign new_addr  = free_q[free_rd];
  assign occupancy = OCC_W'(DEPTH) - free_cnt;

  always_comb begin
    for (int o = 0; o < NUM_OUT; o++) begin
      push[o] = accept && (in_dest == DST_W'(o));
      take[o] = grant_valid[o] && (q_len[o] != '0) &&
                (grant_addr[o*AW +: AW] == q_head[o]);
    end
  end

  always_comb begin
    ret_n = '0;
    for (int o = 0; o < NUM_OUT; o++) begin
      ret_pos[o] = free_wr + ret_n[AW-1:0];
      ret_n      = ret_n + OCC_W'(ret_v[o]);
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      cell_mem[new_addr] <= in_data;
      if (q_len[in_dest] != '0) link[q_tail[in_dest]] <= new_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) free_q[i] <= AW'(i);
      free_rd  <= '0;
      free_wr  <= '0;
      free_cnt <= OCC_W'(DEPTH);
    end else begin
      for (int o = 0; o < NUM_OUT; o++)
        if (ret_v[o]) free_q[ret_pos[o]] <= ret_a[o];
      free_rd  <= free_rd + AW'(accept);
      free_wr  <= free_wr + ret_n[AW-1:0];
      free_cnt <= free_cnt - OCC_W'(accept) + ret_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int o = 0; o < NUM_OUT; o++) begin
        q_head[o] <= '0;
        q_tail[o] <= '0;
        q_len[o]  <= '0;
        ret_a[o]  <= '0;
      end
      ret_v     <= '0;
      out_valid <= '0;
      out_data  <= '0;
    end else begin
      for (int o = 0; o < NUM_OUT; o++) begin
        q_len[o] <= q_len[o] + OCC_W'(push[o]) - OCC_W'(take[o]);
        if (push[o]) q_tail[o] <= new_addr;
        if (push[o] && (q_len[o] == '0 || (take[o] && q_len[o] == OCC_W'(1))))
          q_head[o] <= new_addr;
        else if (take[o])
          q_head[o] <= link[q_head[o]];
        ret_v[o]     <= take[o];
        ret_a[o]     <= q_head[o];
        out_valid[o] <= take[o];
        if (take[o]) out_data[o*DATA_W +: DATA_W] <= cell_mem[q_head[o]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_dest  <= '0;
      req_addr  <= '0;
      drop_cnt  <= '0;
    end else begin
      req_valid <= accept;
      if (accept) begin
        req_dest <= in_dest;
        req_addr <= new_addr;
      end
      if (in_valid && !accept) drop_cnt <= drop_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/shq_input_port_chk.sv
module shq_input_port_chk #(
  parameter int NUM_OUT = 4,
  parameter int DEPTH   = 8,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 16,
  localparam int DST_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  localparam int AW     = $clog2(DEPTH),
  localparam int OCC_W  = AW + 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic [DST_W-1:0]          in_dest,
  input logic [DATA_W-1:0]         in_data,
  input logic                      req_valid,
  input logic [DST_W-1:0]          req_dest,
  input logic [AW-1:0]             req_addr,
  input logic [NUM_OUT-1:0]        grant_valid,
  input logic [NUM_OUT*AW-1:0]     grant_addr,
  input logic [NUM_OUT-1:0]        out_valid,
  input logic [NUM_OUT*DATA_W-1:0] out_data,
  input logic [OCC_W-1:0]          occupancy,
  input logic [CNT_W-1:0]          drop_cnt
);

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= OCC_W'(DEPTH)); // R3

  AST_REQ_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && occupancy < OCC_W'(DEPTH)) |=> (req_valid && req_dest == $past(in_dest))); // R2

  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !req_valid); // R2

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && occupancy == OCC_W'(DEPTH)) |=> (!req_valid && drop_cnt == $past(drop_cnt) + 1'b1)); // R8

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_cnt == $past(drop_cnt) || drop_cnt == $past(drop_cnt) + 1'b1)); // R8

  AST_OUT_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((out_valid & ~$past(grant_valid)) == '0)); // R4

endmodule

bind shq_input_port shq_input_port_chk #(
  .NUM_OUT(NUM_OUT), .DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)
) i_chk (.*);

// File: tb/test_shq_input_port.sv
module test_shq_input_port;
  localparam int CLK_PERIOD = 10;
  localparam int NO = 4;
  localparam int DP = 8;
  localparam int DW = 16;
  localparam int N_VEC = 6;
  localparam logic [20:0] VEC [N_VEC] = '{
    {2'd0, 16'hA000, 3'd0}, {2'd1, 16'hA001, 3'd1}, {2'd0, 16'hA002, 3'd2},
    {2'd2, 16'hA003, 3'd3}, {2'd3, 16'hA004, 3'd4}, {2'd0, 16'hA005, 3'd5}};
  localparam logic [2:0] FILL_ADDR [7] = '{3'd6, 3'd7, 3'd0, 3'd1, 3'd3, 3'd2, 3'd5};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_dest = '0;
  logic [DW-1:0] in_data = '0;
  logic req_valid;
  logic [1:0] req_dest;
  logic [2:0] req_addr;
  logic [NO-1:0] grant_valid = '0;
  logic [NO*3-1:0] grant_addr = '0;
  logic [NO-1:0] out_valid;
  logic [NO*DW-1:0] out_data;
  logic [3:0] occupancy;
  logic [15:0] drop_cnt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shq_input_port i_shq_input_port (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
    .req_valid(req_valid), .req_dest(req_dest), .req_addr(req_addr),
    .grant_valid(grant_valid), .grant_addr(grant_addr),
    .out_valid(out_valid), .out_data(out_data),
    .occupancy(occupancy), .drop_cnt(drop_cnt));

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic arrive(input logic [1:0] d, input logic [DW-1:0] v);
    in_valid = 1'b1; in_dest = d; in_data = v;
    tick();
    in_valid = 1'b0;
  endtask

  task automatic set_grant(input int o, input logic [2:0] a);
    grant_valid[o] = 1'b1;
    grant_addr[o*3 +: 3] = a;
  endtask

  task automatic clr_grant;
    grant_valid = '0;
  endtask

  function automatic logic [DW-1:0] lane(input int o);
    return out_data[o*DW +: DW];
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); tick(); tick();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "occupancy", 32'(occupancy), 0);
    chk("R1", "drop_cnt", 32'(drop_cnt), 0);
    chk("R1", "req_valid", 32'(req_valid), 0);
    chk("R1", "out_valid", 32'(out_valid), 0);

    for (int i = 0; i < N_VEC; i++) begin
      arrive(VEC[i][20:19], VEC[i][18:3]);
      chk("R2", "req_valid", 32'(req_valid), 1);
      chk("R2", "req_dest", 32'(req_dest), 32'(VEC[i][20:19]));
      chk("R9", "req_addr", 32'(req_addr), 32'(VEC[i][2:0]));
      chk("R3", "occupancy rise", 32'(occupancy), 32'(i + 1));
    end
    tick();
    chk("R2", "no req when idle", 32'(req_valid), 0);

    set_grant(0, 3'd2); tick(); clr_grant();
    chk("R5", "non-head grant out_valid", 32'(out_valid), 0);
    tick();
    chk("R5", "non-head grant occupancy", 32'(occupancy), 6);

    set_grant(0, 3'd0); set_grant(1, 3'd1); set_grant(2, 3'd3); tick(); clr_grant();
    chk("R7", "multi out_valid", 32'(out_valid), 32'b0111);
    chk("R4", "lane0 data", 32'(lane(0)), 32'hA000);
    chk("R4", "lane1 data", 32'(lane(1)), 32'hA001);
    chk("R7", "lane2 data", 32'(lane(2)), 32'hA003);
    chk("R3", "occupancy held one cycle", 32'(occupancy), 6);
    tick();
    chk("R3", "occupancy after free", 32'(occupancy), 3);
    chk("R4", "out_valid clears", 32'(out_valid), 0);

    set_grant(1, 3'd1); tick(); clr_grant();
    chk("R6", "empty queue grant", 32'(out_valid), 0);
    tick();
    chk("R6", "empty queue occupancy", 32'(occupancy), 3);

    set_grant(0, 3'd2); tick(); clr_grant();
    chk("R5", "second cell out_valid", 32'(out_valid), 32'b0001);
    chk("R5", "second cell data", 32'(lane(0)), 32'hA002);
    set_grant(0, 3'd5); tick(); clr_grant();
    chk("R5", "third cell data", 32'(lane(0)), 32'hA005);
    tick();
    chk("R3", "occupancy after drain", 32'(occupancy), 1);

    for (int i = 0; i < 7; i++) begin
      arrive(2'd1, 16'hB000 + 16'(i));
      chk("R9", "reused addr", 32'(req_addr), 32'(FILL_ADDR[i]));
    end
    chk("R8", "full occupancy", 32'(occupancy), 8);
    arrive(2'd2, 16'hDEAD);
    chk("R8", "drop no request", 32'(req_valid), 0);
    chk("R8", "drop count", 32'(drop_cnt), 1);
    chk("R8", "drop occupancy", 32'(occupancy), 8);

    set_grant(3, 3'd4); set_grant(1, 3'd6); tick(); clr_grant();
    chk("R7", "pair out_valid", 32'(out_valid), 32'b1010);
    chk("R4", "lane3 data", 32'(lane(3)), 32'hA004);
    chk("R4", "lane1 fill data", 32'(lane(1)), 32'hB000);
    tick();
    chk("R3", "occupancy pair freed", 32'(occupancy), 6);

    arrive(2'd3, 16'hC001);
    chk("R9", "return order low output first", 32'(req_addr), 6);
    in_valid = 1'b1; in_dest = 2'd3; in_data = 16'hC002;
    set_grant(3, 3'd6); tick(); clr_grant(); in_valid = 1'b0;
    chk("R10", "served single cell", 32'(lane(3)), 32'hC001);
    chk("R10", "new cell addr", 32'(req_addr), 4);
    set_grant(3, 3'd4); tick(); clr_grant();
    chk("R10", "new head out_valid", 32'(out_valid), 32'b1000);
    chk("R10", "new head data", 32'(lane(3)), 32'hC002);
    tick();
    chk("R3", "final occupancy", 32'(occupancy), 6);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule